// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block watches the row strobe, the two column strobes (one per byte lane), the write enable and the output enable of an extended-data-out DRAM bus. All five lines are active low and are sampled on a fast system clock. The block names each memory cycle from the order in which the strobe edges arrive, not from a command code. For every cycle it decides it raises a one-clock event. The event carries a 3-bit cycle kind and a 2-bit mask of the byte lanes whose column strobe was low at the deciding sample.

It sits beside a DRAM controller as a protocol monitor. It also counts, in clocks, how long the row strobe stays low and how long it stays high. When either span is shorter than a parameterised minimum, it pulses an error flag. The strobe inputs must already be synchronous to the clock. Each event and each error appears on the clock edge after the sample that decided it.

Kind codes: 0 read, 1 early write, 2 late write, 3 read-modify-write, 4 page column, 5 row-only refresh, 6 column-before-row refresh, 7 hidden refresh. Lane mask bit 0 is the lower byte strobe and bit 1 is the upper byte strobe.

Top module: `ddc_strobe_monitor`

## Requirements
- R1: While reset is asserted and on the first sample after it, evt_valid and timing_err are 0.
- R2: When the row strobe falls and some column strobe is low that was not held low across the preceding row-strobe rise, a kind 6 event is raised, with lanes equal to the column strobes that are low.
- R3: When a column strobe is low at the row-strobe rise, stays low through the whole high period, and is still low when the row strobe falls, a kind 7 event is raised at that fall.
- R4: When the row strobe rises and no column strobe has fallen since it fell, a kind 5 event is raised with lanes 00.
- R5: When write enable is low in the sample where the first column strobe of the row period falls, a kind 1 event is raised in that sample.
- R6: On the first column of a row period with write enable high, a kind 0 event is raised in the first sample where a column strobe and output enable are both low. This sample may be the column fall itself or a later output-enable fall.
- R7: When write enable falls after the first column fall and before a read was reported for that column, a kind 2 event is raised.
- R8: When write enable falls after a read was reported, while the column strobe is still low, a kind 3 event is raised.
- R9: Each column fall after the first column of the same row period raises one kind 4 event in that sample. No further event is raised for that column.
- R10: When the row strobe rises after fewer than RAS_MIN low samples, timing_err pulses for one clock.
- R11: When the row strobe falls after fewer than PRE_MIN high samples, timing_err pulses for one clock. The first fall after reset never errs.
- R12: Every event lasts one clock. Every event other than kind 5 carries a nonzero lane mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| evt_valid | output | 1 | One-clock pulse, a cycle was classified |
| evt_kind | output | 3 | Cycle kind code (0..7) |
| evt_lanes | output | 2 | Active byte lanes, bit0 lower, bit1 upper |
| timing_err | output | 1 | One-clock pulse on a short low or high row-strobe span |

## Verification
A wrong classifier state shows up as a wrong kind code, or a missing or extra event, one clock after the strobe edge that should have been decided. Examples are a stale first-column flag that turns page columns into reads, or a lost hold flag that turns hidden refresh into plain refresh. A wrong span counter shows up at the next row-strobe edge, as an error pulse that is present when it should be absent or absent when it should be present. Because of this, the bench sweeps every lane mask through each access kind and sweeps each span length across its limit.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  typedef enum logic [2:0] {
    CYC_READ     = 3'd0,
    CYC_EARLY_WR = 3'd1,
    CYC_LATE_WR  = 3'd2,
    CYC_RMW      = 3'd3,
    CYC_PAGE     = 3'd4,
    CYC_RAS_ONLY = 3'd5,
    CYC_CBR      = 3'd6,
    CYC_HIDDEN   = 3'd7
  } cyc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_PEND = 3'd2,
    ST_RD   = 3'd3,
    ST_DONE = 3'd4,
    ST_REF  = 3'd5
  } cls_state_e;

  localparam int LANES = 2;

  typedef struct packed {
    logic             ras_fall;
    logic             ras_rise;
    logic             cas_first_fall;
    logic             cas_last_rise;
    logic             cas_low;
    logic [LANES-1:0] lane_low;
    logic             we_low;
    logic             oe_low;
  } strobe_ev_t;

endpackage

// File: rtl/ddc_edge.sv
module ddc_edge
  import ddc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       lcas_n,
  input  logic       ucas_n,
  input  logic       we_n,
  input  logic       oe_n,
  output strobe_ev_t ev
);

  logic [LANES-1:0] lane_low;
  logic             cas_low;
  logic             prev_ras_n;
  logic             prev_cas_low;

  // one bit per byte lane strobe
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_lo
        assign lane_low[g] = ~lcas_n;
      end else begin : g_hi
        assign lane_low[g] = ~ucas_n;
      end
    end
  endgenerate

  assign cas_low = |lane_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ras_n   <= 1'b1;
      prev_cas_low <= 1'b0;
    end else begin
      prev_ras_n   <= ras_n;
      prev_cas_low <= cas_low;
    end
  end

  always_comb begin
    ev.ras_fall       = prev_ras_n & ~ras_n;
    ev.ras_rise       = ~prev_ras_n & ras_n;
    ev.cas_first_fall = ~prev_cas_low & cas_low;
    ev.cas_last_rise  = prev_cas_low & ~cas_low;
    ev.cas_low        = cas_low;
    ev.lane_low       = lane_low;
    ev.we_low         = ~we_n;
    ev.oe_low         = ~oe_n;
  end

endmodule

// File: rtl/ddc_span_timer.sv
module ddc_span_timer #(
  parameter int CNT_W   = 8,
  parameter int RAS_MIN = 4,
  parameter int PRE_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_fall,
  input  logic ras_rise,
  output logic timing_err
);

  localparam logic [CNT_W-1:0] LOW_LIM  = CNT_W'(RAS_MIN);
  localparam logic [CNT_W-1:0] HIGH_LIM = CNT_W'(PRE_MIN);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] span_q, span_d;
  logic             err_d;

  // span_q holds the number of samples seen since the last row edge
  always_comb begin
    span_d = span_q;
    if (ras_fall || ras_rise) begin
      span_d = ONE;
    end else if (!(&span_q)) begin
      span_d = span_q + ONE;
    end
    err_d = (ras_rise && (span_q < LOW_LIM)) ||
            (ras_fall && (span_q < HIGH_LIM));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q     <= '1;
      timing_err <= 1'b0;
    end else begin
      span_q     <= span_d;
      timing_err <= err_d;
    end
  end

endmodule

// File: rtl/ddc_classify.sv
module ddc_classify
  import ddc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_ev_t       ev,
  output logic             evt_valid,
  output cyc_kind_e        evt_kind,
  output logic [LANES-1:0] evt_lanes
);

  cls_state_e       st_q, st_d;
  logic             col_q, col_d;
  logic             held_q, held_d;
  logic             v_d;
  cyc_kind_e        k_d;
  logic [LANES-1:0] l_d;

  always_comb begin
    st_d   = st_q;
    col_d  = col_q;
    held_d = held_q;
    v_d    = 1'b0;
    k_d    = CYC_READ;
    l_d    = ev.lane_low;
    case (st_q)
      ST_IDLE: begin
        held_d = held_q & ev.cas_low;
        if (ev.ras_fall) begin
          col_d = 1'b0;
          if (ev.cas_low) begin
            v_d  = 1'b1;
            k_d  = held_q ? CYC_HIDDEN : CYC_CBR;
            st_d = ST_REF;
          end else begin
            st_d = ST_ROW;
          end
        end
      end
      ST_REF: begin
        if (ev.ras_rise) begin
          st_d   = ST_IDLE;
          held_d = ev.cas_low;
        end
      end
      default: begin
        if (ev.ras_rise) begin
          st_d   = ST_IDLE;
          held_d = ev.cas_low;
          if (st_q == ST_ROW && !col_q && !ev.cas_low) begin
            v_d = 1'b1;
            k_d = CYC_RAS_ONLY;
            l_d = '0;
          end
        end else begin
          case (st_q)
            ST_ROW: begin
              if (ev.cas_first_fall) begin
                if (col_q) begin
                  v_d = 1'b1; k_d = CYC_PAGE; st_d = ST_DONE;
                end else if (ev.we_low) begin
                  v_d = 1'b1; k_d = CYC_EARLY_WR; st_d = ST_DONE;
                end else if (ev.oe_low) begin
                  v_d = 1'b1; k_d = CYC_READ; st_d = ST_RD;
                end else begin
                  st_d = ST_PEND;
                end
              end
            end
            ST_PEND: begin
              if (ev.cas_last_rise) begin
                st_d = ST_ROW; col_d = 1'b1;
              end else if (ev.we_low) begin
                v_d = 1'b1; k_d = CYC_LATE_WR; st_d = ST_DONE;
              end else if (ev.oe_low) begin
                v_d = 1'b1; k_d = CYC_READ; st_d = ST_RD;
              end
            end
            ST_RD: begin
              if (ev.cas_last_rise) begin
                st_d = ST_ROW; col_d = 1'b1;
              end else if (ev.we_low) begin
                v_d = 1'b1; k_d = CYC_RMW; st_d = ST_DONE;
              end
            end
            default: begin
              if (ev.cas_last_rise) begin
                st_d = ST_ROW; col_d = 1'b1;
              end
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      col_q     <= 1'b0;
      held_q    <= 1'b0;
      evt_valid <= 1'b0;
      evt_kind  <= CYC_READ;
      evt_lanes <= '0;
    end else begin
      st_q      <= st_d;
      col_q     <= col_d;
      held_q    <= held_d;
      evt_valid <= v_d;
      if (v_d) begin
        evt_kind  <= k_d;
        evt_lanes <= l_d;
      end
    end
  end

endmodule

// File: rtl/ddc_strobe_monitor.sv
module ddc_strobe_monitor
  import ddc_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RAS_MIN = 4,
  parameter int PRE_MIN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       lcas_n,
  input  logic       ucas_n,
  input  logic       we_n,
  input  logic       oe_n,
  output logic       evt_valid,
  output logic [2:0] evt_kind,
  output logic [1:0] evt_lanes,
  output logic       timing_err
);

  strobe_ev_t ev;
  cyc_kind_e  kind;

  ddc_edge edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ras_n  (ras_n),
    .lcas_n (lcas_n),
    .ucas_n (ucas_n),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .ev     (ev)
  );

  ddc_span_timer #(
    .CNT_W   (CNT_W),
    .RAS_MIN (RAS_MIN),
    .PRE_MIN (PRE_MIN)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras_fall   (ev.ras_fall),
    .ras_rise   (ev.ras_rise),
    .timing_err (timing_err)
  );

  ddc_classify cls_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .evt_valid (evt_valid),
    .evt_kind  (kind),
    .evt_lanes (evt_lanes)
  );

  assign evt_kind = kind;

endmodule

// File: rtl/ddc_strobe_monitor_chk.sv
module ddc_strobe_monitor_chk
  import ddc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       lcas_n,
  input logic       ucas_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       evt_valid,
  input logic [2:0] evt_kind,
  input logic [1:0] evt_lanes,
  input logic       timing_err
);

  a_r2_refresh_cas_low: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_kind == CYC_CBR || evt_kind == CYC_HIDDEN))
      |-> (!$past(ras_n) && !$past(lcas_n && ucas_n)));

  a_r4_ras_only_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == CYC_RAS_ONLY) |-> (evt_lanes == 2'b00 && $past(ras_n)));

  a_r5_early_write_we: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == CYC_EARLY_WR) |-> !$past(we_n));

  a_r6_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == CYC_READ) |-> ($past(we_n) && !$past(oe_n) && !$past(ras_n)));

  a_r8_rmw_we_low: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == CYC_RMW) |-> (!$past(we_n) && !$past(lcas_n && ucas_n)));

  a_r12_lanes_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind != CYC_RAS_ONLY) |-> (evt_lanes != 2'b00));

  a_r10_err_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |-> ($past(ras_n) != $past(ras_n, 2)));

endmodule

bind ddc_strobe_monitor ddc_strobe_monitor_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ras_n      (ras_n),
  .lcas_n     (lcas_n),
  .ucas_n     (ucas_n),
  .we_n       (we_n),
  .oe_n       (oe_n),
  .evt_valid  (evt_valid),
  .evt_kind   (evt_kind),
  .evt_lanes  (evt_lanes),
  .timing_err (timing_err)
);

// File: tb/ddc_strobe_monitor_tb_top.sv
`timescale 1ns/1ps
module ddc_strobe_monitor_tb_top;

  localparam int RMIN = 4;
  localparam int PMIN = 3;
  localparam logic [2:0] K_RD = 3'd0, K_EW = 3'd1, K_LW = 3'd2, K_RMW = 3'd3,
                         K_PG = 3'd4, K_RO = 3'd5, K_CBR = 3'd6, K_HID = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic       evt_valid;
  logic [2:0] evt_kind;
  logic [1:0] evt_lanes;
  logic       timing_err;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ddc_strobe_monitor #(.CNT_W(8), .RAS_MIN(RMIN), .PRE_MIN(PMIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_lanes(evt_lanes), .timing_err(timing_err));

  // drive one sample, then check the registered result of that sample
  task automatic tk(input logic r, input logic [1:0] low, input logic w, input logic o,
                    input logic ev, input logic [2:0] k, input logic [1:0] ln,
                    input logic er, input string tag);
    @(negedge clk);
    ras_n = r; lcas_n = ~low[0]; ucas_n = ~low[1]; we_n = w; oe_n = o;
    @(posedge clk); #1;
    total++;
    if (evt_valid !== ev || (ev && (evt_kind !== k || evt_lanes !== ln)) || timing_err !== er) begin
      bad++;
      $display("FAIL %s: got v=%0b k=%0d l=%b e=%0b exp v=%0b k=%0d l=%b e=%0b",
               tag, evt_valid, evt_kind, evt_lanes, timing_err, ev, k, ln, er);
    end
  endtask

  task automatic q(input logic r, input logic [1:0] low, input logic w, input logic o,
                   input string tag);
    tk(r, low, w, o, 1'b0, 3'd0, 2'b00, 1'b0, tag);
  endtask

  task automatic rise_pre(input string tag);
    tk(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 3'd0, 2'b00, 1'b0, tag);
    q(1'b1, 2'b00, 1'b1, 1'b1, tag);
    q(1'b1, 2'b00, 1'b1, 1'b1, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (evt_valid !== 1'b0 || timing_err !== 1'b0) begin
      bad++;
      $display("FAIL R1: got v=%0b e=%0b exp 0 0", evt_valid, timing_err);
    end
    @(negedge clk); rst_n = 1'b1;
    q(1'b1, 2'b00, 1'b1, 1'b1, "R1 idle");
    q(1'b1, 2'b00, 1'b1, 1'b1, "R1 idle");
    q(1'b1, 2'b00, 1'b1, 1'b1, "R1 idle");

    for (int m = 1; m <= 3; m++) begin
      // R6 read after late OE; first fall after reset checks R11 exemption
      q(1'b0, 2'b00, 1'b1, 1'b1, "R11 first fall / R6 row");
      q(1'b0, m[1:0], 1'b1, 1'b1, "R6 pend");
      tk(1'b0, m[1:0], 1'b1, 1'b0, 1'b1, K_RD, m[1:0], 1'b0, "R6 read");
      q(1'b0, 2'b00, 1'b1, 1'b1, "R12 single pulse");
      rise_pre("R6 close");
      // R5 early write
      q(1'b0, 2'b00, 1'b1, 1'b1, "R5 row");
      tk(1'b0, m[1:0], 1'b0, 1'b1, 1'b1, K_EW, m[1:0], 1'b0, "R5 early write");
      q(1'b0, 2'b00, 1'b0, 1'b1, "R12 no repeat");
      q(1'b0, 2'b00, 1'b1, 1'b1, "R5 hold");
      rise_pre("R5 close");
      // R7 late write
      q(1'b0, 2'b00, 1'b1, 1'b1, "R7 row");
      q(1'b0, m[1:0], 1'b1, 1'b1, "R7 pend");
      tk(1'b0, m[1:0], 1'b0, 1'b1, 1'b1, K_LW, m[1:0], 1'b0, "R7 late write");
      q(1'b0, 2'b00, 1'b1, 1'b1, "R7 close col");
      rise_pre("R7 close");
      // R8 read-modify-write
      q(1'b0, 2'b00, 1'b1, 1'b1, "R8 row");
      tk(1'b0, m[1:0], 1'b1, 1'b0, 1'b1, K_RD, m[1:0], 1'b0, "R6 read same sample");
      tk(1'b0, m[1:0], 1'b0, 1'b0, 1'b1, K_RMW, m[1:0], 1'b0, "R8 rmw");
      q(1'b0, 2'b00, 1'b1, 1'b1, "R8 close col");
      rise_pre("R8 close");
      // R2 column-before-row refresh
      q(1'b1, m[1:0], 1'b1, 1'b1, "R2 cas first");
      tk(1'b0, m[1:0], 1'b1, 1'b1, 1'b1, K_CBR, m[1:0], 1'b0, "R2 cbr");
      q(1'b0, m[1:0], 1'b1, 1'b1, "R2 hold");
      q(1'b0, m[1:0], 1'b1, 1'b1, "R2 hold");
      q(1'b0, 2'b00, 1'b1, 1'b1, "R2 cas up");
      rise_pre("R2 close");
    end

    // R9 page columns
    q(1'b0, 2'b00, 1'b1, 1'b1, "R9 row");
    tk(1'b0, 2'b11, 1'b1, 1'b0, 1'b1, K_RD, 2'b11, 1'b0, "R9 first col read");
    q(1'b0, 2'b00, 1'b1, 1'b1, "R9 precharge col");
    tk(1'b0, 2'b01, 1'b1, 1'b0, 1'b1, K_PG, 2'b01, 1'b0, "R9 page col");
    q(1'b0, 2'b01, 1'b0, 1'b0, "R9 no extra event");
    q(1'b0, 2'b00, 1'b1, 1'b1, "R9 precharge col");
    tk(1'b0, 2'b10, 1'b0, 1'b1, 1'b1, K_PG, 2'b10, 1'b0, "R9 page write col");
    q(1'b0, 2'b00, 1'b1, 1'b1, "R9 precharge col");
    rise_pre("R9 close");

    // R4 row-only refresh
    q(1'b0, 2'b00, 1'b1, 1'b1, "R4 row");
    q(1'b0, 2'b00, 1'b0, 1'b0, "R4 row");
    q(1'b0, 2'b00, 1'b1, 1'b1, "R4 row");
    q(1'b0, 2'b00, 1'b1, 1'b1, "R4 row");
    tk(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, K_RO, 2'b00, 1'b0, "R4 ras only");
    q(1'b1, 2'b00, 1'b1, 1'b1, "R4 pre");
    q(1'b1, 2'b00, 1'b1, 1'b1, "R4 pre");

    // R3 hidden refresh after a read with lower CAS held
    q(1'b0, 2'b00, 1'b1, 1'b1, "R3 row");
    tk(1'b0, 2'b01, 1'b1, 1'b0, 1'b1, K_RD, 2'b01, 1'b0, "R3 read");
    q(1'b0, 2'b01, 1'b1, 1'b0, "R3 hold");
    q(1'b0, 2'b01, 1'b1, 1'b0, "R3 hold");
    q(1'b1, 2'b01, 1'b1, 1'b0, "R3 ras up cas held");
    q(1'b1, 2'b01, 1'b1, 1'b1, "R3 pre");
    q(1'b1, 2'b01, 1'b1, 1'b1, "R3 pre");
    tk(1'b0, 2'b01, 1'b1, 1'b1, 1'b1, K_HID, 2'b01, 1'b0, "R3 hidden");
    q(1'b0, 2'b01, 1'b1, 1'b1, "R3 hold");
    q(1'b0, 2'b01, 1'b1, 1'b1, "R3 hold");
    q(1'b0, 2'b00, 1'b1, 1'b1, "R3 cas up");
    rise_pre("R3 close");

    // R10 sweep of low span around RAS_MIN
    for (int d = 1; d <= RMIN + 1; d++) begin
      q(1'b0, 2'b00, 1'b1, 1'b1, "R10 fall");
      for (int i = 1; i < d; i++) q(1'b0, 2'b00, 1'b1, 1'b1, "R10 low");
      tk(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, K_RO, 2'b00, (d < RMIN), "R10 rise");
      q(1'b1, 2'b00, 1'b1, 1'b1, "R10 pre");
      q(1'b1, 2'b00, 1'b1, 1'b1, "R10 pre");
    end

    // R11 sweep of high span around PRE_MIN
    for (int h = 1; h <= PMIN + 1; h++) begin
      q(1'b0, 2'b00, 1'b1, 1'b1, "R11 fall");
      for (int i = 0; i < 3; i++) q(1'b0, 2'b00, 1'b1, 1'b1, "R11 low");
      tk(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, K_RO, 2'b00, 1'b0, "R11 rise");
      for (int i = 1; i < h; i++) q(1'b1, 2'b00, 1'b1, 1'b1, "R11 high");
      tk(1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 3'd0, 2'b00, (h < PMIN), "R11 short precharge");
      for (int i = 0; i < 3; i++) q(1'b0, 2'b00, 1'b1, 1'b1, "R11 low");
      tk(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, K_RO, 2'b00, 1'b0, "R11 rise");
      q(1'b1, 2'b00, 1'b1, 1'b1, "R11 pre");
      q(1'b1, 2'b00, 1'b1, 1'b1, "R11 pre");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule